// File: doc/BRIEF.md
# Frame-Slip Elastic Store

This block absorbs the small rate difference between a side that produces E1 channel bytes and a side that consumes them. It holds two 32-byte frames. The producer pushes one byte per write enable and can mark the first byte of a frame. The consumer pulls one byte per read strobe and gets a marker with each byte that begins a frame.

When the producer runs ahead, the oldest buffered frame is dropped whole. When the consumer runs ahead, the frame it just consumed is played again whole. Slips are decided only as the consumer starts a new frame, so frame alignment is never broken. Each slip kind sets a sticky status bit. Host software clears a bit by writing a 1 to it.

Both sides share one clock and are paced by their enables. The storage has a 6-bit byte address. Each pointer carries one more lap bit above that address, so that the fill level stays unambiguous across a whole wrap.

Top module: `esb_frame_slip_store`

## Requirements
- R1: After reset both status bits read 0, the write pointer sits at byte 32 and the read pointer at byte 0, so the fill level is 32. The first read therefore returns the byte at offset 0 of frame half 0, with the frame marker set.
- R2: A write with `wr_en` stores `wr_data` at the write pointer and advances it by one. A read with `rd_en` returns the byte at the read pointer on `rd_data` in the next cycle and advances the pointer by one. A read and a write to the same address in one cycle return the old byte. With neither enable set, both pointers hold.
- R3: A write with `wr_fs` set while the write pointer is not on a frame boundary (offset bits 4:0 non-zero) first moves the pointer to offset 0 of the next frame half. The byte is stored there. With the pointer already on a boundary, `wr_fs` changes nothing.
- R4: `rd_fs` is valid with `rd_data` and is 1 exactly when the byte read sat at offset 0 of a frame half.
- R5: On a read at a frame boundary with fill level (write pointer minus read pointer, 7-bit modulo) below 32, the read moves back 32 bytes. The previous complete frame is read again, and status bit 0 is set.
- R6: On a read at a frame boundary with fill level 64 or more, the read moves forward 32 bytes. One buffered frame is dropped, and status bit 1 is set.
- R7: A read that is not at a frame boundary never slips. The read pointer advances by exactly one.
- R8: Status bits 1 (frame dropped) and 0 (frame repeated) stay set until cleared.
- R9: A host write with `host_we` clears each status bit whose `host_wdata` bit is 1. Bits written with 0 are left unchanged.
- R10: A slip event and a host clear of the same bit in one cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write one byte this cycle |
| wr_fs | input | 1 | Byte being written begins a frame |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Read one byte this cycle |
| rd_data | output | 8 | Byte read, valid the cycle after `rd_en` |
| rd_fs | output | 1 | Byte on `rd_data` begins a frame |
| host_we | input | 1 | Host write to the status bits |
| host_wdata | input | 2 | Write-one-to-clear mask, bit 1 drop, bit 0 repeat |
| slip_status | output | 2 | Sticky slip bits, bit 1 drop, bit 0 repeat |

## Verification
The hardest case to reach is a slip event that lands in the same cycle as a host clear of the same bit. It needs the read pointer to sit exactly on a frame boundary, the fill level to be past a threshold, and a host write to coincide with that very read. The bench keeps its own pointer model. It walks the reader to a boundary while holding the writer back, or pushes the writer forward while the reader waits. It issues the clear together with the read that triggers the slip, for both the drop and the repeat direction. Randomized traffic with a near-balanced rate then produces further slips in both directions between these directed steps.

// File: rtl/esb_pkg.sv
package esb_pkg;
  typedef enum logic [1:0] {
    SLIP_NONE   = 2'd0,
    SLIP_REPEAT = 2'd1,
    SLIP_DELETE = 2'd2
  } slip_e;

  localparam int unsigned FLG_REPEAT = 0;
  localparam int unsigned FLG_DELETE = 1;
  localparam int unsigned FLG_W      = 2;
endpackage

// File: rtl/esb_store.sv
module esb_store #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Storage has no reset; a read of the address being written returns old data.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/esb_wr_ctrl.sv
module esb_wr_ctrl #(
  parameter int unsigned FB = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_fs,
  output logic [FB:0]   waddr,
  output logic [FB+1:0] wptr
);
  localparam int unsigned PW = FB + 2;
  localparam logic [PW-1:0] ONE   = {{(PW-1){1'b0}}, 1'b1};
  localparam logic [PW-1:0] FRAME = ONE << FB;

  logic [PW-1:0] wptr_q, wptr_d, base;
  logic          aligned;

  always_comb begin
    aligned = (wptr_q[FB-1:0] == '0);
    base    = wptr_q;
    if (wr_fs && !aligned) base = {wptr_q[PW-1:FB], {FB{1'b0}}} + FRAME;
    wptr_d  = wr_en ? base + ONE : wptr_q;
    waddr   = base[FB:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wptr_q <= FRAME;
    else        wptr_q <= wptr_d;
  end

  assign wptr = wptr_q;

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wptr_q));
  // R3
  wr_realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_fs) |=> (wptr_q[FB-1:0] == ONE[FB-1:0]));
endmodule

// File: rtl/esb_rd_ctrl.sv
module esb_rd_ctrl
  import esb_pkg::*;
#(
  parameter int unsigned FB = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [FB+1:0] wptr,
  output logic [FB:0]   raddr,
  output logic          head,
  output slip_e         slip
);
  localparam int unsigned PW = FB + 2;
  localparam logic [PW-1:0] ONE        = {{(PW-1){1'b0}}, 1'b1};
  localparam logic [PW-1:0] FRAME      = ONE << FB;
  localparam logic [PW-1:0] TWO_FRAMES = FRAME << 1;

  logic [PW-1:0] rptr_q, rptr_d, fill, base;
  logic          at_bnd;

  always_comb begin
    fill   = wptr - rptr_q;
    at_bnd = (rptr_q[FB-1:0] == '0);
    slip   = SLIP_NONE;
    base   = rptr_q;
    if (rd_en && at_bnd) begin
      if (fill < FRAME) begin
        slip = SLIP_REPEAT;
        base = rptr_q - FRAME;
      end else if (fill >= TWO_FRAMES) begin
        slip = SLIP_DELETE;
        base = rptr_q + FRAME;
      end
    end
    rptr_d = rd_en ? base + ONE : rptr_q;
    raddr  = base[FB:0];
    head   = at_bnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rptr_q <= '0;
    else        rptr_q <= rptr_d;
  end

  // R7
  rd_midframe_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !at_bnd) |=> (rptr_q == $past(rptr_q) + ONE));
  // R7
  rd_no_slip_midframe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !at_bnd |-> (slip == SLIP_NONE));
  // R5
  rd_repeat_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slip == SLIP_REPEAT) |=> ((wptr - rptr_q) >= FRAME - ONE));
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rptr_q));
endmodule

// File: rtl/esb_flags.sv
module esb_flags
  import esb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  slip_e            slip,
  input  logic             host_we,
  input  logic [FLG_W-1:0] host_wdata,
  output logic [FLG_W-1:0] flags
);
  logic [FLG_W-1:0] set_vec, clr_vec, flags_q, flags_d;

  always_comb begin
    set_vec             = '0;
    set_vec[FLG_REPEAT] = (slip == SLIP_REPEAT);
    set_vec[FLG_DELETE] = (slip == SLIP_DELETE);
    clr_vec             = host_we ? host_wdata : '0;
    flags_d             = (flags_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

  for (genvar i = 0; i < FLG_W; i++) begin : g_bit
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !clr_vec[i]) |=> flags_q[i]);
    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !flags_q[i]);
    // R10
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flags_q[i]);
  end
endmodule

// File: rtl/esb_frame_slip_store.sv
module esb_frame_slip_store
  import esb_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned FB = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_fs,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  output logic             rd_fs,
  input  logic             host_we,
  input  logic [FLG_W-1:0] host_wdata,
  output logic [FLG_W-1:0] slip_status
);
  localparam int unsigned AW = FB + 1;
  localparam int unsigned PW = FB + 2;

  logic [1:0]    rst_pipe;
  logic          rst_core_n;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wptr;
  logic          head, rd_fs_q;
  slip_e         slip;

  // Reset asserts at once, releases two clocks after rst_n rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  esb_wr_ctrl #(.FB(FB)) u_wr (
    .clk   (clk),
    .rst_n (rst_core_n),
    .wr_en (wr_en),
    .wr_fs (wr_fs),
    .waddr (waddr),
    .wptr  (wptr)
  );

  esb_rd_ctrl #(.FB(FB)) u_rd (
    .clk   (clk),
    .rst_n (rst_core_n),
    .rd_en (rd_en),
    .wptr  (wptr),
    .raddr (raddr),
    .head  (head),
    .slip  (slip)
  );

  esb_store #(.DW(DW), .AW(AW)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (waddr),
    .wdata (wr_data),
    .re    (rd_en),
    .raddr (raddr),
    .rdata (rd_data)
  );

  esb_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .slip       (slip),
    .host_we    (host_we),
    .host_wdata (host_wdata),
    .flags      (slip_status)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  rd_fs_q <= 1'b0;
    else if (rd_en)   rd_fs_q <= head;
  end
  assign rd_fs = rd_fs_q;

  // R4
  rd_marker_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_en && raddr[FB-1:0] != '0) |=> !rd_fs);
endmodule

// File: tb/esb_frame_slip_store_tb.sv
`timescale 1ns/1ps
module esb_frame_slip_store_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_fs, rd_en, host_we;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       rd_fs;
  logic [1:0] host_wdata, slip_status;

  always #5 clk = ~clk;

  esb_frame_slip_store u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_fs(wr_fs), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_fs(rd_fs), .host_we(host_we),
    .host_wdata(host_wdata), .slip_status(slip_status)
  );

  int nchk = 0;
  int nfail = 0;
  int mw, mr, mflags;
  logic [7:0] mmem [64];
  bit mvalid [64];
  string cur_tag;
  int last_ev;

  task automatic chk(bit ok, string tag, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int fill_lvl();
    return (mw - mr) & 127;
  endfunction

  task automatic step(bit we, bit wfs, logic [7:0] wd, bit re, bit hwe, logic [1:0] hwd);
    int base, a, ev, b;
    bit exp_v, exp_fs;
    logic [7:0] exp_d;
    ev = 0; exp_v = 0; exp_fs = 0; exp_d = '0;
    if (re) begin
      base = mr;
      if ((mr % 32) == 0) begin
        if (fill_lvl() < 32) begin base = (mr - 32) & 127; ev = 1; end
        else if (fill_lvl() >= 64) begin base = (mr + 32) & 127; ev = 2; end
      end
      a = base & 63;
      exp_d = mmem[a]; exp_v = mvalid[a]; exp_fs = ((a % 32) == 0);
      mr = (base + 1) & 127;
    end
    mflags = (mflags & ~(hwe ? int'(hwd) : 0)) | ev;
    if (we) begin
      b = mw;
      if (wfs && (b % 32) != 0) b = ((b | 31) + 1) & 127;
      a = b & 63;
      mmem[a] = wd; mvalid[a] = 1'b1;
      mw = (b + 1) & 127;
    end
    last_ev = ev;
    wr_en = we; wr_fs = wfs; wr_data = wd; rd_en = re; host_we = hwe; host_wdata = hwd;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; wr_fs = 0; rd_en = 0; host_we = 0;
    if (re) begin
      chk(rd_fs == exp_fs, "R4", rd_fs, exp_fs);
      if (exp_v)
        chk(rd_data == exp_d, ev == 1 ? "R5" : ev == 2 ? "R6" : cur_tag, rd_data, exp_d);
    end
    chk(slip_status == mflags[1:0],
        ev != 0 ? (hwe ? "R10" : "R8") : (hwe ? "R9" : "R8"), slip_status, mflags);
  endtask

  initial begin
    #1_500_000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    rst_n = 0; wr_en = 0; wr_fs = 0; wr_data = 0; rd_en = 0; host_we = 0; host_wdata = 0;
    mw = 32; mr = 0; mflags = 0;
    for (int i = 0; i < 64; i++) mvalid[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: status clear after reset
    chk(slip_status == 2'b00, "R1", slip_status, 0);

    // R1: first read at half 0 offset 0, fill 32 so no slip while balanced
    cur_tag = "R1";
    step(1, 1, 8'h10, 1, 0, 0);
    chk(rd_fs == 1'b1, "R1", rd_fs, 1);
    for (int i = 1; i < 64; i++) step(1, 0, 8'(8'h10 + i), 1, 0, 0);
    chk(slip_status == 2'b00, "R1", slip_status, 0);

    // R2 / R7: mid-frame reads with idle gaps, ordered data
    cur_tag = "R7";
    for (int i = 0; i < 20; i++) step(i % 2 == 0, 0, 8'(8'h60 + i), i % 3 != 0, 0, 0);
    cur_tag = "R2";
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0);

    // R5: starve the writer until a boundary read repeats a frame
    cur_tag = "R5";
    while (!((mr % 32) == 0 && fill_lvl() < 32)) step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    chk(last_ev == 1 && slip_status[0], "R5", slip_status, 1);
    // R9: writing 0 leaves the bit, writing 1 clears it
    step(0, 0, 0, 0, 1, 2'b00);
    chk(slip_status[0] == 1'b1, "R9", slip_status, 1);
    step(0, 0, 0, 0, 1, 2'b01);
    chk(slip_status == 2'b00, "R9", slip_status, 0);

    // R3: frame marker at an unaligned write position realigns
    cur_tag = "R3";
    while ((mw % 32) == 0) step(1, 0, 8'hA0, 0, 0, 0);
    step(1, 1, 8'hC3, 0, 0, 0);
    chk((mw % 32) == 1, "R3", mw, 1);

    // R6: push writer forward until a boundary read drops a frame
    cur_tag = "R6";
    while (!((mr % 32) == 0 && fill_lvl() >= 64))
      step(fill_lvl() < 64, 0, 8'($urandom), (mr % 32) != 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    chk(last_ev == 2 && slip_status[1], "R6", slip_status, 2);
    for (int i = 0; i < 40; i++) step(1, (mw % 32) == 0, 8'($urandom), 1, 0, 0);

    // R10: drop event coincides with clear of the same bit
    cur_tag = "R10";
    step(0, 0, 0, 0, 1, 2'b11);
    while (!((mr % 32) == 0 && fill_lvl() >= 64))
      step(fill_lvl() < 64, 0, 8'($urandom), (mr % 32) != 0, 0, 0);
    step(0, 0, 0, 1, 1, 2'b10);
    chk(slip_status[1] == 1'b1, "R10", slip_status, 2);
    // R10: repeat event coincides with clear of the same bit
    while (!((mr % 32) == 0 && fill_lvl() < 32)) step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 1, 1, 2'b01);
    chk(slip_status[0] == 1'b1, "R10", slip_status, 3);

    // Random traffic with near-balanced rates (R2, R4, R5, R6, R7, R8, R9)
    cur_tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      bit we, re, hwe;
      we  = ($urandom % 100) < 50;
      re  = ($urandom % 100) < 50;
      hwe = ($urandom % 100) < 4;
      step(we, we && (mw % 32) == 0, 8'($urandom), re, hwe, 2'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule